// File: doc/BRIEF.md
# Programmable SPI Transaction Sequencer

This block runs one serial-flash transaction each time software triggers it. The transaction is built from up to five phases, always in this order: an optional opcode byte, 0 to 4 address bytes, a run of write bytes, a run of filler ("dummy") bytes and a run of read bytes. A configuration word sets the length of each phase. The bytes come from an opcode word, an address word and a bank of write words. Bytes clocked in from the serial input are stored into a bank of read words.

Each clock cycle during a transaction carries one beat. A beat is one bit in every phase except the filler phase, where it may carry 1, 2, 4 or 8 bits. When the last beat is done the sequencer sets a sticky ready flag and drops its busy flag. It can also drive a chip select for the duration of the transaction, or leave the chip select to software.

The controller is a single state machine with the states IDLE, CMD, ADDR, WRITE, DUMMY, READ and DONE. It has these transitions:
- IDLE→first phase on an accepted trigger.
- Phase→next non-empty phase on the last beat of a phase. Empty phases are skipped.
- Last phase→DONE.
- IDLE→DONE when every phase is empty.
- DONE→IDLE after one cycle.

Top module: `spi_txn_engine`

## Requirements
- R1: When `cfg_word[10]` is 1, the CMD phase sends `cmd_word[7:0]`, most significant bit first, one bit per beat, with `beat_bits`=1 and the bit on `beat_data[0]`.
- R2: `cfg_word[13:11]` gives the address byte count A, and values 5 to 7 act as 4. The ADDR phase sends `addr_word` bytes A-1 down to 0. Each byte goes out most significant bit first, one bit per beat.
- R3: `cfg_word[20:16]` gives the write byte count W (0 to 31). Write byte i is taken from lane i%4 (bits 8·lane+7:8·lane) of write word min(i/4,3). Write word k occupies `wr_words[32k+31:32k]`. Each byte goes out most significant bit first.
- R4: `cfg_word[23:21]` gives the filler byte count. Filler byte 0 is `cmd_word[15:8]`, filler byte 1 is `cmd_word[23:16]`, and every later filler byte is `cmd_word[31:24]`.
- R5: `cfg_word[7:6]`=n sets 2^n bits per filler beat. `beat_bits` shows 2^n. Each filler byte is sent as 8/2^n beats, lowest chunk first, and each chunk is right-aligned in `beat_data`.
- R6: `cfg_word[28:24]` gives the read byte count R. During READ, `beat_data` is 0 and `miso` is sampled at the end of each beat, most significant bit first. Read byte i goes into lane i%4 of read word i/4 in `rd_words`. Bytes with i ≥ 16 are clocked in but discarded, and read bytes not received keep their old value.
- R7: Beats come one per clock with no gaps, in the order CMD, ADDR, WRITE, DUMMY, READ, skipping empty phases. `beat_valid` is high only in those states.
- R8: After reset, `busy` and `rdy` are 0 and `rd_words` is 0. At completion `rdy` becomes 1 and `busy` 0 together. `rdy` then stays set until `rdy_clr`, and a completion in the same cycle as `rdy_clr` wins.
- R9: `irq` is high exactly when `rdy` and `rdy_ie` are both 1.
- R10: An `exec_req` seen while `busy` is 1 is ignored and starts no further transaction.
- R11: With `sw_cs`=1, the chip select `cs_n[dev_sel]` captured at the trigger is low during the beats of the transaction, and all `cs_n` lines are high otherwise. A `dev_sel` at or above `CS_COUNT` drives no line.
- R12: With `sw_cs`=0, `cs_n[dev_sel]` is held low by software at all times, including through a transaction, and the sequencer does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Phase lengths and filler width |
| cmd_word | input | 32 | Opcode byte and filler sources |
| addr_word | input | 32 | Address bytes |
| wr_words | input | DATA_WORDS*WORD_W | Write data words |
| dev_sel | input | 2 | Target chip-select number |
| sw_cs | input | 1 | 1: sequencer drives chip select; 0: software holds it low |
| rdy_ie | input | 1 | Ready interrupt enable |
| exec_req | input | 1 | Start trigger |
| rdy_clr | input | 1 | Clear the ready flag |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transaction in progress |
| rdy | output | 1 | Sticky completion flag |
| irq | output | 1 | Ready interrupt |
| cs_n | output | CS_COUNT | Active-low chip selects |
| beat_valid | output | 1 | A beat is on the wire this cycle |
| beat_bits | output | 4 | Bits carried by this beat (1, 2, 4, 8) |
| beat_data | output | 8 | Beat payload, right-aligned |
| rd_words | output | DATA_WORDS*WORD_W | Read data words |

## Verification
A wrong phase state or a wrong counter shows at the ports at once, in the same cycle. The beat stream then gains or loses beats, carries a byte from the wrong source, or sends chunks in the wrong order. Each beat is compared with a bench-built expected stream as it appears. A fault in the read path shows only after completion, as a byte in the wrong lane or an overwritten byte past the sixteenth. A fault in the ready or chip-select logic shows within one cycle of the trigger or of completion.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_WRITE, ST_DUMMY, ST_READ, ST_DONE
    } txn_state_e;

    typedef struct packed {
        logic       cmd_en;
        logic [2:0] addr_n;
        logic [4:0] wr_n;
        logic [2:0] dm_n;
        logic [1:0] dm_shift;
        logic [4:0] rd_n;
    } txn_len_t;

    localparam int MAX_ADDR_BYTES = 4;

    function automatic txn_len_t decode_cfg(input logic [31:0] c);
        txn_len_t l;
        l.cmd_en   = c[10];
        l.addr_n   = (c[13:11] > 3'(MAX_ADDR_BYTES)) ? 3'(MAX_ADDR_BYTES) : c[13:11];
        l.wr_n     = c[20:16];
        l.dm_n     = c[23:21];
        l.dm_shift = c[7:6];
        l.rd_n     = c[28:24];
        return l;
    endfunction

    // First non-empty phase after state s; DONE if none is left.
    function automatic txn_state_e next_phase(input txn_state_e s, input txn_len_t l);
        txn_state_e n;
        n = ST_DONE;
        if (l.rd_n   != 0 && s < ST_READ)  n = ST_READ;
        if (l.dm_n   != 0 && s < ST_DUMMY) n = ST_DUMMY;
        if (l.wr_n   != 0 && s < ST_WRITE) n = ST_WRITE;
        if (l.addr_n != 0 && s < ST_ADDR)  n = ST_ADDR;
        if (l.cmd_en      && s < ST_CMD)   n = ST_CMD;
        return n;
    endfunction

endpackage

// File: rtl/spi_txn_byte_mux.sv
module spi_txn_byte_mux
    import spi_txn_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int DATA_WORDS = 4
) (
    input  txn_state_e                   state,
    input  logic [4:0]                   byte_idx,
    input  logic [2:0]                   addr_n,
    input  logic [31:0]                  cmd_word,
    input  logic [31:0]                  addr_word,
    input  logic [DATA_WORDS*WORD_W-1:0] wr_words,
    output logic [7:0]                   tx_byte
);
    localparam int LANES = WORD_W / 8;

    always_comb begin
        int sel;
        int word;
        int lane;
        tx_byte = 8'h00;
        sel  = 0;
        word = 0;
        lane = 0;
        unique case (state)
            ST_CMD:   tx_byte = cmd_word[7:0];
            ST_ADDR: begin
                sel = int'(addr_n) - 1 - int'(byte_idx);
                if (sel < 0) sel = 0;
                tx_byte = addr_word[8*sel +: 8];
            end
            ST_WRITE: begin
                word = int'(byte_idx) / LANES;
                if (word > DATA_WORDS - 1) word = DATA_WORDS - 1;
                lane = int'(byte_idx) % LANES;
                tx_byte = wr_words[word*WORD_W + lane*8 +: 8];
            end
            ST_DUMMY: begin
                if (byte_idx == 5'd0)      tx_byte = cmd_word[15:8];
                else if (byte_idx == 5'd1) tx_byte = cmd_word[23:16];
                else                       tx_byte = cmd_word[31:24];
            end
            default:  tx_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/spi_txn_read_store.sv
module spi_txn_read_store #(
    parameter int WORD_W     = 32,
    parameter int DATA_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         store_en,
    input  logic [4:0]                   byte_idx,
    input  logic [7:0]                   din,
    output logic [DATA_WORDS*WORD_W-1:0] rd_words
);
    localparam int SLOTS = DATA_WORDS * WORD_W / 8;

    // Flat byte slot b is lane b%4 of word b/4; indices past SLOTS never match.
    for (genvar b = 0; b < SLOTS; b++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_words[b*8 +: 8] <= 8'h00;
            else if (store_en && byte_idx == 5'(b))
                rd_words[b*8 +: 8] <= din;
        end
    end

endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
    import spi_txn_pkg::*;
#(
    parameter int CS_COUNT   = 3,
    parameter int WORD_W     = 32,
    parameter int DATA_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [31:0]                  cfg_word,
    input  logic [31:0]                  cmd_word,
    input  logic [31:0]                  addr_word,
    input  logic [DATA_WORDS*WORD_W-1:0] wr_words,
    input  logic [1:0]                   dev_sel,
    input  logic                         sw_cs,
    input  logic                         rdy_ie,
    input  logic                         exec_req,
    input  logic                         rdy_clr,
    input  logic                         miso,
    output logic                         busy,
    output logic                         rdy,
    output logic                         irq,
    output logic [CS_COUNT-1:0]          cs_n,
    output logic                         beat_valid,
    output logic [3:0]                   beat_bits,
    output logic [7:0]                   beat_data,
    output logic [DATA_WORDS*WORD_W-1:0] rd_words
);
    txn_state_e state;
    txn_len_t   lens_q;
    logic [1:0] dev_q;
    logic       swcs_q;
    logic [3:0] pos;
    logic [4:0] byte_cnt;
    logic [6:0] shift_q;
    logic [3:0] step;
    logic [4:0] cur_len;
    logic       in_phase;
    logic       last_bit;
    logic       last_byte;
    logic [7:0] tx_byte;
    logic [8:0] chunk_mask;

    assign in_phase = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_WRITE) ||
                      (state == ST_DUMMY) || (state == ST_READ);

    always_comb begin
        step = (state == ST_DUMMY) ? (4'd1 << lens_q.dm_shift) : 4'd1;
        unique case (state)
            ST_ADDR:  cur_len = {2'b00, lens_q.addr_n};
            ST_WRITE: cur_len = lens_q.wr_n;
            ST_DUMMY: cur_len = {2'b00, lens_q.dm_n};
            ST_READ:  cur_len = lens_q.rd_n;
            default:  cur_len = 5'd1;
        endcase
        last_bit  = (pos + step) == 4'd8;
        last_byte = byte_cnt == (cur_len - 5'd1);
    end

    spi_txn_byte_mux #(.WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS)) u_mux (
        .state    (state),
        .byte_idx (byte_cnt),
        .addr_n   (lens_q.addr_n),
        .cmd_word (cmd_word),
        .addr_word(addr_word),
        .wr_words (wr_words),
        .tx_byte  (tx_byte)
    );

    spi_txn_read_store #(.WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_en(state == ST_READ && pos == 4'd7),
        .byte_idx(byte_cnt),
        .din     ({shift_q, miso}),
        .rd_words(rd_words)
    );

    // State register and phase counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lens_q   <= '0;
            dev_q    <= '0;
            swcs_q   <= 1'b0;
            pos      <= '0;
            byte_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (exec_req) begin
                        lens_q   <= decode_cfg(cfg_word);
                        dev_q    <= dev_sel;
                        swcs_q   <= sw_cs;
                        pos      <= '0;
                        byte_cnt <= '0;
                        state    <= next_phase(ST_IDLE, decode_cfg(cfg_word));
                    end
                end
                ST_CMD, ST_ADDR, ST_WRITE, ST_DUMMY, ST_READ: begin
                    if (last_bit) begin
                        pos <= '0;
                        if (last_byte) begin
                            byte_cnt <= '0;
                            state    <= next_phase(state, lens_q);
                        end else begin
                            byte_cnt <= byte_cnt + 5'd1;
                        end
                    end else begin
                        pos <= pos + step;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Receive shifter and sticky ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            rdy     <= 1'b0;
        end else begin
            if (state == ST_READ) shift_q <= {shift_q[5:0], miso};
            if (state == ST_DONE)  rdy <= 1'b1;
            else if (rdy_clr)      rdy <= 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        chunk_mask = (9'd1 << step) - 9'd1;
        busy       = state != ST_IDLE;
        irq        = rdy && rdy_ie;
        beat_valid = in_phase;
        beat_bits  = in_phase ? step : 4'd0;
        beat_data  = 8'h00;
        if (state == ST_DUMMY)
            beat_data = (tx_byte >> pos) & chunk_mask[7:0];
        else if (in_phase)
            beat_data = {7'b0, tx_byte[3'd7 - pos[2:0]]};
        for (int i = 0; i < CS_COUNT; i++) begin
            cs_n[i] = !((!sw_cs && dev_sel == 2'(i)) ||
                        (in_phase && swcs_q && dev_q == 2'(i)));
        end
    end

endmodule

// File: rtl/spi_txn_engine_chk.sv
module spi_txn_engine_chk #(
    parameter int CS_COUNT = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                exec_req,
    input logic                sw_cs,
    input logic                rdy_ie,
    input logic                busy,
    input logic                rdy,
    input logic                irq,
    input logic [CS_COUNT-1:0] cs_n,
    input logic                beat_valid,
    input logic [3:0]          beat_bits
);
    AST_RDY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(busy) && !busy);                                   // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rdy && rdy_ie);                                                 // R9
    AST_BEAT_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> busy);                                                   // R7
    AST_BEAT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> $onehot(beat_bits));                                     // R5
    AST_START_BY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy || $past(exec_req));                                    // R10
    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_cs && !busy) |-> &cs_n);                                            // R11
endmodule

bind spi_txn_engine spi_txn_engine_chk #(.CS_COUNT(CS_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_req  (exec_req),
    .sw_cs     (sw_cs),
    .rdy_ie    (rdy_ie),
    .busy      (busy),
    .rdy       (rdy),
    .irq       (irq),
    .cs_n      (cs_n),
    .beat_valid(beat_valid),
    .beat_bits (beat_bits)
);

// File: tb/spi_txn_engine_test.sv
module spi_txn_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 3;
    localparam int WD_CYCLES = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cfg_word = '0, cmd_word = '0, addr_word = '0;
    logic [127:0] wr_words = '0;
    logic [1:0]   dev_sel = '0;
    logic         sw_cs = 1'b1, rdy_ie = 1'b0, exec_req = 1'b0, rdy_clr = 1'b0, miso = 1'b0;
    logic         busy, rdy, irq, beat_valid;
    logic [NCS-1:0] cs_n;
    logic [3:0]   beat_bits;
    logic [7:0]   beat_data;
    logic [127:0] rd_words;

    int n_chk = 0, n_fail = 0;
    logic [7:0]   exp_data [0:1023];
    logic [3:0]   exp_bits [0:1023];
    logic [7:0]   rd_src   [0:31];
    logic [127:0] rd_model = '0;
    int exp_n, pre_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_txn_engine #(.CS_COUNT(NCS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cmd_word(cmd_word),
        .addr_word(addr_word), .wr_words(wr_words), .dev_sel(dev_sel), .sw_cs(sw_cs),
        .rdy_ie(rdy_ie), .exec_req(exec_req), .rdy_clr(rdy_clr), .miso(miso),
        .busy(busy), .rdy(rdy), .irq(irq), .cs_n(cs_n), .beat_valid(beat_valid),
        .beat_bits(beat_bits), .beat_data(beat_data), .rd_words(rd_words)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog act=%0d exp=<%0d", WD_CYCLES, WD_CYCLES);
        summary();
        $finish;
    end

    task automatic push(input logic [7:0] d, input logic [3:0] b);
        exp_data[exp_n] = d;
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    task automatic push_byte(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) push({7'b0, v[k]}, 4'd1);
    endtask

    // Expected beat stream from the requirements.
    task automatic build(input logic [31:0] c);
        int a, st;
        logic [7:0] v;
        exp_n = 0;
        if (c[10]) push_byte(cmd_word[7:0]);                        // R1
        a = int'(c[13:11]); if (a > 4) a = 4;                        // R2
        for (int j = 0; j < a; j++) push_byte(addr_word[8*(a-1-j) +: 8]);
        for (int i = 0; i < int'(c[20:16]); i++) begin               // R3
            int w;
            w = (i / 4 > 3) ? 3 : i / 4;
            push_byte(wr_words[w*32 + (i%4)*8 +: 8]);
        end
        st = 1 << c[7:6];                                            // R5
        for (int j = 0; j < int'(c[23:21]); j++) begin               // R4
            v = (j == 0) ? cmd_word[15:8] : (j == 1) ? cmd_word[23:16] : cmd_word[31:24];
            for (int p = 0; p < 8; p += st)
                push(8'((v >> p) & ((1 << st) - 1)), 4'(st));
        end
        pre_n = exp_n;
        for (int k = 0; k < 8 * int'(c[28:24]); k++) push(8'h00, 4'd1); // R6
        for (int i = 0; i < int'(c[28:24]) && i < 16; i++) rd_model[i*8 +: 8] = rd_src[i];
    endtask

    task automatic run(input logic [31:0] c, input logic [1:0] dev, input logic swcs,
                       input bit poke, input string tag);
        int beats, mism, cs_bad, r;
        logic [NCS-1:0] exp_cs;
        logic [7:0] first_act, first_exp;
        cfg_word = c; dev_sel = dev; sw_cs = swcs;
        for (int i = 0; i < 32; i++) rd_src[i] = 8'($urandom);
        build(c);
        exp_cs = ~(NCS'(1) << dev);
        if (int'(dev) >= NCS) exp_cs = '1;
        beats = 0; mism = 0; cs_bad = 0; first_act = 0; first_exp = 0;
        exec_req = 1'b1;
        @(negedge clk);
        exec_req = 1'b0;
        while (busy) begin
            exec_req = poke && beats == 5;
            if (beat_valid) begin
                if (beats >= exp_n || beat_data !== exp_data[beats] || beat_bits !== exp_bits[beats]) begin
                    if (mism == 0) begin
                        first_act = beat_data;
                        first_exp = (beats < exp_n) ? exp_data[beats] : 8'hxx;
                    end
                    mism++;
                end
                if (cs_n !== exp_cs) cs_bad++;
                r = beats - pre_n;
                miso = (r >= 0 && r < 256) ? rd_src[r/8][7 - r%8] : 1'b0;
                beats++;
            end
            @(negedge clk);
        end
        exec_req = 1'b0;
        chk(mism == 0 && beats == exp_n, {tag, " beat stream"}, {first_act, 32'(beats)}, {first_exp, 32'(exp_n)});
        chk(cs_bad == 0, swcs ? "R11 cs during txn" : "R12 cs held by software", 128'(cs_bad), 0);
        chk(rdy === 1'b1 && busy === 1'b0, "R8 ready at completion", {rdy, busy}, 2'b10);
        chk(rd_words === rd_model, "R6 read words", rd_words, rd_model);
        chk(irq === rdy_ie, "R9 irq follows ready and enable", irq, rdy_ie);
        chk(cs_n === (swcs ? {NCS{1'b1}} : exp_cs), swcs ? "R11 cs idle" : "R12 cs kept low", cs_n, swcs ? {NCS{1'b1}} : exp_cs);
        rdy_clr = 1'b1;
        @(negedge clk);
        rdy_clr = 1'b0;
        chk(rdy === 1'b0 && irq === 1'b0, "R8 rdy cleared", {rdy, irq}, 2'b00);
    endtask

    initial begin
        void'($urandom(32'd2024));
        wr_words = {$urandom, $urandom, $urandom, $urandom};
        cmd_word = 32'h3C_96_5A_A5;
        addr_word = 32'h12_34_56_78;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && rdy === 1'b0 && irq === 1'b0 && cs_n === '1 && beat_valid === 1'b0 && rd_words === '0,
            "R8 reset state", {busy, rdy, irq, cs_n, beat_valid}, {3'b000, {NCS{1'b1}}, 1'b0});

        run(32'h0000_0400, 2'd0, 1'b1, 0, "R1");                       // opcode only
        run(32'h0000_2000, 2'd1, 1'b1, 0, "R2");                       // 4 address bytes
        run(32'h0000_1800, 2'd1, 1'b1, 0, "R2");                       // 3 address bytes
        run(32'h0000_3000, 2'd2, 1'b1, 0, "R2 clamp");                 // field 6 acts as 4
        run(32'h0014_0000, 2'd0, 1'b1, 0, "R3");                       // 20 write bytes
        run(32'h0080_0080, 2'd0, 1'b1, 0, "R4 R5 4-bit");              // 4 filler, 4 bits/beat
        run(32'h00A0_00C0, 2'd0, 1'b1, 0, "R4 R5 8-bit");              // 5 filler, 8 bits/beat
        run(32'h0060_0040, 2'd0, 1'b1, 0, "R5 2-bit");
        run(32'h1400_0000, 2'd0, 1'b1, 0, "R6");                       // 20 read bytes
        run(32'h0000_0000, 2'd0, 1'b1, 0, "R7 empty");
        rdy_ie = 1'b1;
        run(32'h0302_0C00, 2'd2, 1'b1, 1, "R10");                      // trigger while busy
        repeat (3) begin
            chk(busy === 1'b0 && beat_valid === 1'b0, "R10 no second txn", {busy, beat_valid}, 2'b00);
            @(negedge clk);
        end
        run(32'h0201_0C00, 2'd3, 1'b1, 0, "R11 out of range");
        run(32'h0402_2C00, 2'd1, 1'b0, 0, "R12");
        sw_cs = 1'b1;

        // R8 completion beats a simultaneous clear
        cfg_word = 32'h0000_0400; dev_sel = 2'd0;
        for (int i = 0; i < 32; i++) rd_src[i] = 8'h00;
        build(cfg_word);
        exec_req = 1'b1; @(negedge clk); exec_req = 1'b0;
        rdy_clr = 1'b1;
        while (busy) @(negedge clk);
        rdy_clr = 1'b0;
        chk(rdy === 1'b1, "R8 completion wins over clear", rdy, 1'b1);
        rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0;

        for (int t = 0; t < 40; t++) begin
            cmd_word = $urandom; addr_word = $urandom;
            wr_words = {$urandom, $urandom, $urandom, $urandom};
            rdy_ie = 1'($urandom);
            run($urandom & 32'h1FFF_3CC0, 2'($urandom % NCS), 1'b1, 0, "R7 random");
        end

        summary();
        $finish;
    end
endmodule